// File: doc/BRIEF.md
# I2C Open-Drain Byte Engine

This block is the bit-level master for a two-wire serial bus. It never drives either line high. Each line has a pull-low enable: asserting the enable pulls the line to 0, and clearing it releases the line so that the external pull-up makes a 1. Both lines are read back through a synchroniser. The engine takes one command at a time over a valid/ready handshake. The commands are bus START, bus STOP, write one byte, and read one byte. A read either acknowledges the byte or ends the transfer.

Every SCL low and high phase lasts a fixed number of system clocks, derived from a clocks-per-microsecond parameter. When the engine releases SCL it does not start timing the high phase until it sees the line actually high. This lets a slow slave stretch the clock. If SCL stays low for the whole wait window (1000 µs by default), the command is abandoned, both lines are released, and a timeout flag is returned. After any STOP the bus is held free for a bus-free interval (60 µs by default) before the next command is taken. A higher-level sequencer builds complete transactions from these commands.

Top module: `i2cb_engine`

## Requirements
- R1: After reset both pull-low enables are 0 (lines released), `cmd_ready` is 1 and `rsp_done` is 0. A 1 on the bus is always produced by releasing the line, never by driving it.
- R2: Opcode 2'b00 (START) releases SDA, then releases SCL and waits for it high. It then pulls SDA low while SCL is high, then pulls SCL low. Both enables are 1 when it completes.
- R3: Opcode 2'b01 (STOP) pulls SCL and SDA low, then releases SCL and waits for it high. It then releases SDA while SCL is high. Both lines are released when it completes.
- R4: After the SDA release of any STOP, `rsp_done` and `cmd_ready` stay low for at least `BUF_US*CLKS_PER_US` clocks.
- R5: Opcode 2'b10 (WRITE) sends `cmd_wdata` MSB first, one SCL high pulse per bit. On a ninth pulse SDA is released and sampled while SCL is high. `rsp_ack` is 1 exactly when that sample was 0.
- R6: When a WRITE completes without timeout, SCL is left pulled low.
- R7: Opcode 2'b11 (READ) releases SDA and samples eight bits MSB first, each while SCL is high. The byte is returned on `rsp_rdata`.
- R8: A READ with `cmd_last`=0 pulls SDA low during a ninth clock pulse (ACK), releases SDA once SCL is low again, and sends no STOP.
- R9: A READ with `cmd_last`=1 gives the ninth pulse with SDA released (NACK) and then performs the STOP of R3 within the same command.
- R10: A slave holding SCL low after release delays the high phase. The transfer still completes correctly with `rsp_timeout`=0.
- R11: If a released SCL is not seen high within `SCL_WAIT_US*CLKS_PER_US` clocks, the command completes with `rsp_timeout`=1 and both lines are released. The next command clears the flag.
- R12: Every SCL low and high phase lasts at least `PHASE_US*CLKS_PER_US` clocks. During the nine bit pulses of a byte command, SDA does not change while SCL is high.
- R13: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until after `rsp_done`, which is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 00 START, 01 STOP, 10 WRITE, 11 READ |
| cmd_wdata | input | 8 | Byte to send on WRITE |
| cmd_last | input | 1 | READ only: 1 gives NACK then STOP, 0 gives ACK |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte received by the last READ |
| rsp_ack | output | 1 | Ninth-bit sample was low |
| rsp_timeout | output | 1 | SCL stayed low past the wait window |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong phase or bit counter shows up at once as a too-short SCL phase, an SDA change while SCL is high, or a tenth clock pulse. These are visible within one bit time. A bad shift register or sample point corrupts the bit pattern a slave model decodes from the bus, and also the returned byte or ACK, by the end of the same command. Faulty wait or bus-free timing shows up as a missing timeout, a timeout during a legal stretch, or a `rsp_done` that arrives sooner after the STOP edge than the bus-free interval allows.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_STOP  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ST_A,   // both released, wait for SCL high
    S_ST_B,   // SDA low under high SCL
    S_ST_C,   // SCL low
    S_SP_A,   // both low
    S_SP_B,   // SCL released, wait for high
    S_SP_C,   // SDA released, bus-free interval
    S_B_LO,   // bit low phase, data set up
    S_B_HI,   // bit high phase, sample at end
    S_B_END,  // SCL low, SDA released after ninth bit
    S_DONE,
    S_FAIL
  } state_e;

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cb_down_counter.sv
module i2cb_down_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] val,
  output logic             zero
);
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int PHASE_US    = 5,
  parameter int SCL_WAIT_US = 1000,
  parameter int BUF_US      = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_last,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       rsp_ack,
  output logic       rsp_timeout,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int PHASE_CLKS = CLKS_PER_US * PHASE_US;
  localparam int BUF_CLKS   = CLKS_PER_US * BUF_US;
  localparam int TO_CLKS    = CLKS_PER_US * SCL_WAIT_US;
  localparam int TMR_MAX    = (PHASE_CLKS > BUF_CLKS) ? PHASE_CLKS : BUF_CLKS;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int TO_W       = $clog2(TO_CLKS + 1);
  localparam logic [TMR_W-1:0] PH_LD   = TMR_W'(PHASE_CLKS - 1);
  localparam logic [TMR_W-1:0] BUF_LD  = TMR_W'(BUF_CLKS - 1);
  localparam logic [TO_W-1:0]  TO_LAST = TO_W'(TO_CLKS - 1);

  state_e           state, nxt;
  op_e              op_q;
  logic             last_q, hi_seen, to_flag, done_q;
  logic [8:0]       tx, tx_nxt, rx;
  logic [3:0]       bit_cnt;
  logic [TO_W-1:0]  to_cnt;
  logic             scl_s, sda_s, tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             is_hi, hi_done, timed_out, shift_now;
  logic             scl_oe_q, sda_oe_q, scl_pull, sda_pull;

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (.clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
  i2cb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (.clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  i2cb_down_counter #(.WIDTH(TMR_W)) u_phase_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  assign is_hi     = (state == S_ST_A) || (state == S_SP_B) || (state == S_B_HI);
  assign hi_done   = is_hi && hi_seen && tmr_zero;
  assign timed_out = is_hi && !hi_seen && !scl_s && (to_cnt == TO_LAST);

  // Next state, phase timer load and transmit shifter
  always_comb begin
    nxt       = state;
    tmr_load  = 1'b0;
    tmr_val   = PH_LD;
    tx_nxt    = tx;
    shift_now = 1'b0;
    if (is_hi && !hi_seen && scl_s) tmr_load = 1'b1;
    case (state)
      S_IDLE: if (cmd_valid) begin
        tx_nxt = (op_e'(cmd_op) == OP_WRITE) ? {cmd_wdata, 1'b1} : {8'hFF, cmd_last};
        case (op_e'(cmd_op))
          OP_START: nxt = S_ST_A;
          OP_STOP:  begin nxt = S_SP_A; tmr_load = 1'b1; end
          default:  begin nxt = S_B_LO; tmr_load = 1'b1; end
        endcase
      end
      S_ST_A:  if (hi_done) begin nxt = S_ST_B; tmr_load = 1'b1; end
      S_ST_B:  if (tmr_zero) begin nxt = S_ST_C; tmr_load = 1'b1; end
      S_ST_C:  if (tmr_zero) nxt = S_DONE;
      S_SP_A:  if (tmr_zero) nxt = S_SP_B;
      S_SP_B:  if (hi_done) begin nxt = S_SP_C; tmr_load = 1'b1; tmr_val = BUF_LD; end
      S_SP_C:  if (tmr_zero) nxt = S_DONE;
      S_B_LO:  if (tmr_zero) nxt = S_B_HI;
      S_B_HI:  if (hi_done) begin
        shift_now = 1'b1;
        tx_nxt    = {tx[7:0], 1'b1};
        tmr_load  = 1'b1;
        nxt       = (bit_cnt == 4'd8) ? S_B_END : S_B_LO;
      end
      S_B_END: if (tmr_zero) begin
        if (op_q == OP_READ && last_q) begin nxt = S_SP_A; tmr_load = 1'b1; end
        else nxt = S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      S_FAIL:  nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
    if (timed_out) nxt = S_FAIL;
  end

  // Line pattern of the state being entered (1 = pull low)
  always_comb begin
    scl_pull = 1'b0;
    sda_pull = 1'b0;
    case (nxt)
      S_ST_B:  sda_pull = 1'b1;
      S_ST_C:  begin scl_pull = 1'b1; sda_pull = 1'b1; end
      S_SP_A:  begin scl_pull = 1'b1; sda_pull = 1'b1; end
      S_SP_B:  sda_pull = 1'b1;
      S_B_LO:  begin scl_pull = 1'b1; sda_pull = ~tx_nxt[8]; end
      S_B_HI:  sda_pull = ~tx_nxt[8];
      S_B_END: scl_pull = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_START;
      last_q   <= 1'b0;
      tx       <= '1;
      rx       <= '1;
      bit_cnt  <= '0;
      hi_seen  <= 1'b0;
      to_cnt   <= '0;
      to_flag  <= 1'b0;
      done_q   <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state  <= nxt;
      tx     <= tx_nxt;
      done_q <= (nxt == S_DONE);
      if (nxt != state) begin
        hi_seen <= 1'b0;
        to_cnt  <= '0;
      end else if (is_hi && !hi_seen) begin
        if (scl_s) hi_seen <= 1'b1;
        else       to_cnt  <= to_cnt + 1'b1;
      end
      if (state == S_IDLE && cmd_valid) begin
        op_q    <= op_e'(cmd_op);
        last_q  <= cmd_last;
        bit_cnt <= '0;
        to_flag <= 1'b0;
      end
      if (shift_now) begin
        rx      <= {rx[7:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (nxt == S_FAIL) to_flag <= 1'b1;
      if (nxt != S_IDLE && nxt != S_DONE) begin
        scl_oe_q <= scl_pull;
        sda_oe_q <= sda_pull;
      end
    end
  end

  assign cmd_ready   = (state == S_IDLE);
  assign rsp_done    = done_q;
  assign rsp_rdata   = rx[8:1];
  assign rsp_ack     = ~rx[0];
  assign rsp_timeout = to_flag;
  assign scl_oe      = scl_oe_q;
  assign sda_oe      = sda_oe_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready); // R13
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R13
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rsp_done && rsp_timeout |-> !scl_oe && !sda_oe); // R11
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    to_cnt <= TO_LAST); // R11
  AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == S_B_HI) && hi_seen && !tmr_zero |=> $stable(sda_oe) && $stable(scl_oe)); // R12
  AST_WRITE_LEAVES_LOW: assert property (@(posedge clk) disable iff (rst)
    rsp_done && !rsp_timeout && (op_q == OP_WRITE) |-> scl_oe); // R6

endmodule

// File: tb/i2cb_engine_bench.sv
module i2cb_engine_bench;
  localparam int CPU  = 2;
  localparam int PHU  = 2;
  localparam int WTU  = 1000;
  localparam int BFU  = 60;
  localparam int PH   = CPU * PHU;
  localparam int BUFC = CPU * BFU;
  localparam int TOC  = CPU * WTU;
  localparam int M_NONE = 0, M_WACK = 1, M_WNAK = 2, M_RD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_last = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_ready, rsp_done, rsp_ack, rsp_timeout, scl_oe, sda_oe;
  logic [7:0] rsp_rdata;
  logic       slv_scl_low = 1'b0, slv_sda_low = 1'b0;
  wire        scl_bus = ~scl_oe & ~slv_scl_low;
  wire        sda_bus = ~sda_oe & ~slv_sda_low;

  i2cb_engine #(.CLKS_PER_US(CPU), .PHASE_US(PHU), .SCL_WAIT_US(WTU), .BUF_US(BFU)) u_i2cb_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_last(cmd_last), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_ack(rsp_ack), .rsp_timeout(rsp_timeout), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  // stimulus configuration, written by the initial block only
  int         cfg_mode = 0, cfg_seq = 0, cfg_st_at = -1, cfg_st_len = 0;
  logic [7:0] cfg_byte = 8'h00;

  // behavioural bus model and slave, evaluated every clock
  int         cyc = 0, seen_seq = 0, fall_cnt = 0, hold_left = 0, rises = 0, nbits = 0;
  int         hi_w = 0, lo_w = 0, n_starts = 0, n_stops = 0, stop_cyc = 0, done_cyc = 0;
  int         mon_checks = 0, mon_errs = 0;
  logic [8:0] bits = '0;
  logic       scl_p = 1'b1, sda_p = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      scl_p = 1'b1; sda_p = 1'b1; hi_w = 0; lo_w = 0;
    end else begin
      if (cfg_seq != seen_seq) begin
        seen_seq = cfg_seq; fall_cnt = 0; nbits = 0; rises = 0; bits = '0;
        slv_scl_low = 1'b0; hold_left = 0;
        slv_sda_low = (cfg_mode == M_RD) ? ~cfg_byte[7] : 1'b0;
        if (cfg_st_at == 0) begin slv_scl_low = 1'b1; hold_left = cfg_st_len; end
      end else if (hold_left > 0) begin
        hold_left = hold_left - 1;
        if (hold_left == 0) slv_scl_low = 1'b0;
      end
      if (rsp_done) done_cyc = cyc;
      if (scl_p && scl_bus && sda_p && !sda_bus) n_starts = n_starts + 1;
      if (scl_p && scl_bus && !sda_p && sda_bus) begin n_stops = n_stops + 1; stop_cyc = cyc; end
      // R12: SDA steady while SCL high inside the nine bit pulses
      if (cfg_mode != M_NONE && rises >= 1 && rises <= 9 && scl_p && scl_bus) begin
        mon_checks = mon_checks + 1;
        if (sda_p != sda_bus) begin
          mon_errs = mon_errs + 1;
          $display("FAIL R12: SDA moved during SCL high, actual %0b expected %0b", sda_bus, sda_p);
        end
      end
      if (!scl_p && scl_bus) begin
        rises = rises + 1;
        if (nbits < 9) bits = {bits[7:0], sda_bus};
        nbits = nbits + 1;
        mon_checks = mon_checks + 1;
        if (lo_w < PH) begin
          mon_errs = mon_errs + 1;
          $display("FAIL R12: SCL low phase, actual %0d expected >= %0d", lo_w, PH);
        end
        hi_w = 0;
      end
      if (scl_p && !scl_bus) begin
        mon_checks = mon_checks + 1;
        if (hi_w < PH) begin
          mon_errs = mon_errs + 1;
          $display("FAIL R12: SCL high phase, actual %0d expected >= %0d", hi_w, PH);
        end
        lo_w = 0;
        fall_cnt = fall_cnt + 1;
        if (cfg_mode == M_WACK) begin
          if (fall_cnt == 8) slv_sda_low = 1'b1;
          if (fall_cnt == 9) slv_sda_low = 1'b0;
        end else if (cfg_mode == M_RD) begin
          slv_sda_low = (fall_cnt < 8) ? ~cfg_byte[7 - fall_cnt] : 1'b0;
        end
        if (fall_cnt == cfg_st_at) begin slv_scl_low = 1'b1; hold_left = cfg_st_len; end
      end
      if (scl_bus) hi_w = hi_w + 1; else lo_w = lo_w + 1;
      scl_p = scl_bus; sda_p = sda_bus;
    end
  end

  int checks = 0, errors = 0, waited = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] wd, input logic lst,
                        input int mode, input logic [7:0] sb, input int st_at, input int st_len);
    @(posedge clk);
    #1;
    cfg_mode = mode; cfg_byte = sb; cfg_st_at = st_at; cfg_st_len = st_len;
    cfg_seq = cfg_seq + 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_last = lst;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R13 busy after accept", cmd_ready, 1'b0);
    waited = 1;
    while (!rsp_done && waited < TOC + 4000) begin
      @(negedge clk);
      waited = waited + 1;
    end
    chk("R13 done seen", rsp_done, 1'b1);
    @(negedge clk);
    chk("R13 done single cycle", rsp_done, 1'b0);
  endtask

  int st0, sp0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl released", scl_oe, 1'b0);
    chk("R1 sda released", sda_oe, 1'b0);
    chk("R1 ready", cmd_ready, 1'b1);
    chk("R1 no done", rsp_done, 1'b0);

    st0 = n_starts;
    run_op(2'b00, 8'h00, 1'b0, M_NONE, 8'h00, -1, 0);
    chk("R2 start edge", n_starts - st0, 1);
    chk("R2 scl low", scl_oe, 1'b1);
    chk("R2 sda low", sda_oe, 1'b1);

    run_op(2'b10, 8'hA5, 1'b0, M_WACK, 8'h00, -1, 0);
    chk("R5 bits A5+ack", {23'd0, bits}, {23'd0, 8'hA5, 1'b0});
    chk("R5 ack", rsp_ack, 1'b1);
    chk("R6 scl left low", scl_oe, 1'b1);

    run_op(2'b10, 8'h3C, 1'b0, M_WNAK, 8'h00, -1, 0);
    chk("R5 bits 3C+nack", {23'd0, bits}, {23'd0, 8'h3C, 1'b1});
    chk("R5 nack", rsp_ack, 1'b0);
    chk("R6 scl left low", scl_oe, 1'b1);

    sp0 = n_stops;
    run_op(2'b11, 8'h00, 1'b0, M_RD, 8'h96, -1, 0);
    chk("R7 rdata 96", rsp_rdata, 8'h96);
    chk("R8 master ack bit", bits[0], 1'b0);
    chk("R8 no stop", n_stops - sp0, 0);
    chk("R8 sda released", sda_oe, 1'b0);
    chk("R8 scl low", scl_oe, 1'b1);

    sp0 = n_stops;
    run_op(2'b11, 8'h00, 1'b1, M_RD, 8'h5A, -1, 0);
    chk("R7 rdata 5A", rsp_rdata, 8'h5A);
    chk("R9 nack bit", bits[0], 1'b1);
    chk("R9 stop issued", n_stops - sp0, 1);
    chk("R3 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R4 gap after read stop", (done_cyc - stop_cyc) >= BUFC, 1'b1);

    run_op(2'b00, 8'h00, 1'b0, M_NONE, 8'h00, -1, 0);
    run_op(2'b10, 8'hC3, 1'b0, M_WACK, 8'h00, 3, 40);
    chk("R10 bits C3+ack", {23'd0, bits}, {23'd0, 8'hC3, 1'b0});
    chk("R10 ack", rsp_ack, 1'b1);
    chk("R10 no timeout", rsp_timeout, 1'b0);
    chk("R10 stretched", waited >= 18 * PH + 40, 1'b1);

    sp0 = n_stops;
    run_op(2'b01, 8'h00, 1'b0, M_NONE, 8'h00, -1, 0);
    chk("R3 stop edge", n_stops - sp0, 1);
    chk("R3 released", {scl_oe, sda_oe}, 2'b00);
    chk("R4 bus free gap", (done_cyc - stop_cyc) >= BUFC, 1'b1);

    run_op(2'b00, 8'h00, 1'b0, M_NONE, 8'h00, -1, 0);
    run_op(2'b10, 8'h81, 1'b0, M_WACK, 8'h00, 0, 1000000000);
    chk("R11 timeout flag", rsp_timeout, 1'b1);
    chk("R11 released", {scl_oe, sda_oe}, 2'b00);
    chk("R11 waited long enough", waited >= TOC, 1'b1);
    chk("R11 not too long", waited <= TOC + PH + 20, 1'b1);

    st0 = n_starts;
    run_op(2'b00, 8'h00, 1'b0, M_NONE, 8'h00, -1, 0);
    chk("R11 flag cleared", rsp_timeout, 1'b0);
    chk("R2 start after recovery", n_starts - st0, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errs + 1);
    $finish;
  end
endmodule